// File: doc/BRIEF.md
# Burst Beat Address Generator

This block produces the byte address of every beat of a memory burst on a wide data bus. A controller loads it once per burst with a start address, a beat count minus one, a beat size code and a burst kind. It then pulses a step input each time a beat is consumed. The block shows the current beat address, the same address rounded down to a whole bus word, a flag that marks the final beat, and a flag that reports an incrementing burst that would run past a 4 KB page.

Three burst kinds are handled: fixed (every beat hits one address), incrementing, and wrapping inside a window whose size equals the whole transfer. Start addresses that are not aligned to the beat size are rounded down before the first beat. The block carries no data and takes part in no handshake. Load and step are plain control pulses that are accepted in the cycle they are high, with no back-pressure. It does not judge whether a wrapping burst length is legal.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset `active`, `last` and `page_cross` are 0 and `beat_addr` is 0.
- R2: A cycle with `load` high makes `active` 1 on the next cycle, and `beat_addr` then shows `start_addr` rounded down to a multiple of 2^`size` bytes.
- R3: For `kind` 1 (incrementing) and the reserved code 3, each accepted step adds 2^`size` to `beat_addr`.
- R4: For `kind` 0 (fixed), `beat_addr` keeps its first value for every beat of the burst.
- R5: For `kind` 2 (wrapping), the total size T = 2^`size` x (`beat_cnt`+1) sets a window from `start_addr` rounded down to a multiple of T up to that value plus T. Each step adds 2^`size`, and an address that reaches the top of the window goes back to the bottom.
- R6: `word_addr` equals `beat_addr` rounded down to a multiple of BUS_BYTES (8 by default).
- R7: `last` is 1 while the burst is active and the beat index equals `beat_cnt`. A step on that beat makes `active` and `last` 0 on the next cycle.
- R8: A step while `active` is 0 has no effect: `beat_addr` and `active` stay unchanged.
- R9: `page_cross` is 1 for a burst of kind 1 or 3 when 0x1000 minus the low 12 bits of the aligned start address is less than T. It is 0 for kinds 0 and 2 and holds its value until the next load.
- R10: `load` wins over `step` in the same cycle and restarts a burst in progress at its new first beat.
- R11: With `step` low, `beat_addr` and `last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Captures a new burst description |
| start_addr | input | ADDR_W | Byte address given with the burst |
| beat_cnt | input | LEN_W | Number of beats minus one |
| size | input | SIZE_W | Beat size as log2 of bytes |
| kind | input | 2 | 0 fixed, 1 incrementing, 2 wrapping, 3 treated as incrementing |
| step | input | 1 | Advances to the next beat |
| beat_addr | output | ADDR_W | Byte address of the current beat |
| word_addr | output | ADDR_W | Beat address rounded down to a bus word |
| active | output | 1 | A burst is in progress |
| last | output | 1 | Current beat is the final one |
| page_cross | output | 1 | Loaded incrementing burst runs past a 4 KB page |

## Verification
The bench goes after the wrap point. A design that compared against the wrong upper bound would run past the window, or return to the unaligned start instead of the window base. Unaligned starts check rounding by the beat size: a design that skipped it would show the raw start byte. The page check is driven with a burst that ends exactly on the page edge and one that goes a single beat past it. An off-by-one comparison flags the first, and a missing reserved-kind decode misses the second. Idle steps, a load during a burst and steps on the last beat catch counters that keep running after the burst ends or give step priority over load.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic [1:0] {
    BK_FIXED = 2'd0,
    BK_INCR  = 2'd1,
    BK_WRAP  = 2'd2,
    BK_RSVD  = 2'd3
  } burst_kind_e;
endpackage

// File: rtl/bag_plan.sv
module bag_plan
  import bag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  beat_cnt,
  input  logic [SIZE_W-1:0] size,
  input  burst_kind_e       kind,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] win_lo,
  output logic [ADDR_W-1:0] win_hi,
  output logic              crosses
);
  localparam int XFER_W = LEN_W + (1 << SIZE_W);

  logic [XFER_W-1:0] beats;
  logic [XFER_W-1:0] total;
  logic [ADDR_W-1:0] total_a;
  logic [ADDR_W-1:0] beat_mask;
  logic [12:0]       page_left;

  always_comb begin
    beats      = XFER_W'(beat_cnt) + XFER_W'(1);
    total      = beats << size;
    total_a    = ADDR_W'(total);
    beat_mask  = ~((ADDR_W'(1) << size) - ADDR_W'(1));
    first_addr = start_addr & beat_mask;
    win_lo     = start_addr & ~(total_a - ADDR_W'(1));
    win_hi     = win_lo + total_a;
    page_left  = 13'h1000 - {1'b0, first_addr[11:0]};
    crosses    = ((kind == BK_INCR) || (kind == BK_RSVD)) &&
                 (32'(page_left) < 32'(total));
  end
endmodule

// File: rtl/bag_next.sv
module bag_next
  import bag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [SIZE_W-1:0] size,
  input  burst_kind_e       kind,
  input  logic [ADDR_W-1:0] win_lo,
  input  logic [ADDR_W-1:0] win_hi,
  output logic [ADDR_W-1:0] nxt_addr
);
  logic [ADDR_W-1:0] bumped;

  always_comb begin
    bumped = cur_addr + (ADDR_W'(1) << size);
    unique case (kind)
      BK_FIXED: nxt_addr = cur_addr;
      BK_WRAP:  nxt_addr = (bumped == win_hi) ? win_lo : bumped;
      default:  nxt_addr = bumped;
    endcase
  end
endmodule

// File: rtl/bag_count.sv
module bag_count #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [LEN_W-1:0] beat_cnt,
  output logic             active,
  output logic             last,
  output logic             advance
);
  logic [LEN_W-1:0] idx_q;
  logic [LEN_W-1:0] end_q;

  assign last    = active && (idx_q == end_q);
  assign advance = active && step && !load && !last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      end_q  <= '0;
      active <= 1'b0;
    end else if (load) begin
      idx_q  <= '0;
      end_q  <= beat_cnt;
      active <= 1'b1;
    end else if (active && step) begin
      if (last) active <= 1'b0;
      else      idx_q  <= idx_q + LEN_W'(1);
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 8,
  parameter int SIZE_W    = 3,
  parameter int BUS_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  beat_cnt,
  input  logic [SIZE_W-1:0] size,
  input  logic [1:0]        kind,
  input  logic              step,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [ADDR_W-1:0] word_addr,
  output logic              active,
  output logic              last,
  output logic              page_cross
);
  localparam int WORD_LSB = $clog2(BUS_BYTES);

  burst_kind_e       kind_in;
  burst_kind_e       kind_q;
  logic [SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0] lo_q, hi_q;
  logic [ADDR_W-1:0] first_a, lo_a, hi_a, nxt_a;
  logic              cross_a;
  logic              advance;

  assign kind_in = burst_kind_e'(kind);

  bag_plan #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) plan_i (
    .start_addr (start_addr),
    .beat_cnt   (beat_cnt),
    .size       (size),
    .kind       (kind_in),
    .first_addr (first_a),
    .win_lo     (lo_a),
    .win_hi     (hi_a),
    .crosses    (cross_a)
  );

  bag_next #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) next_i (
    .cur_addr (beat_addr),
    .size     (size_q),
    .kind     (kind_q),
    .win_lo   (lo_q),
    .win_hi   (hi_q),
    .nxt_addr (nxt_a)
  );

  bag_count #(.LEN_W(LEN_W)) count_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .beat_cnt (beat_cnt),
    .active   (active),
    .last     (last),
    .advance  (advance)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_addr  <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      size_q     <= '0;
      kind_q     <= BK_FIXED;
      page_cross <= 1'b0;
    end else if (load) begin
      beat_addr  <= first_a;
      lo_q       <= lo_a;
      hi_q       <= hi_a;
      size_q     <= size;
      kind_q     <= kind_in;
      page_cross <= cross_a;
    end else if (advance) begin
      beat_addr  <= nxt_a;
    end
  end

  assign word_addr = {beat_addr[ADDR_W-1:WORD_LSB], WORD_LSB'(0)};
endmodule

// File: rtl/bag_chk.sv
module bag_chk
  import bag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              step,
  input logic              active,
  input logic              last,
  input logic              page_cross,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [SIZE_W-1:0] size_q,
  input burst_kind_e       kind_q
);
  // R2
  load_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active);

  // R7
  last_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> active);

  // R7
  end_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && step && !load) |=> (!active && !last));

  // R4
  fixed_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step && !load && kind_q == BK_FIXED) |=> $stable(beat_addr));

  // R3
  incr_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step && !load && !last && kind_q == BK_INCR) |=>
      (beat_addr == $past(beat_addr) + (ADDR_W'(1) << $past(size_q))));

  // R8
  idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !load) |=> ($stable(beat_addr) && !active));

  // R9
  cross_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(page_cross));
endmodule

bind burst_addr_gen bag_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .load       (load),
  .step       (step),
  .active     (active),
  .last       (last),
  .page_cross (page_cross),
  .beat_addr  (beat_addr),
  .size_q     (size_q),
  .kind_q     (kind_q)
);

// File: tb/burst_addr_gen_tb_top.sv
`timescale 1ns/1ps
module burst_addr_gen_tb_top;
  localparam int AW = 32;
  localparam int BB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0]    beat_cnt = '0;
  logic [2:0]    size = '0;
  logic [1:0]    kind = '0;
  logic          step = 1'b0;
  logic [AW-1:0] beat_addr, word_addr;
  logic          active, last, page_cross;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  burst_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr),
    .beat_cnt(beat_cnt), .size(size), .kind(kind), .step(step),
    .beat_addr(beat_addr), .word_addr(word_addr), .active(active),
    .last(last), .page_cross(page_cross)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_step();
    @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic do_load(input logic [AW-1:0] a, input int n, input int sz, input int k);
    @(negedge clk);
    load = 1'b1; start_addr = a; beat_cnt = 8'(n); size = 3'(sz); kind = 2'(k);
    @(negedge clk);
    load = 1'b0;
  endtask

  // Walks a whole burst, predicting each beat from the rules in R2..R9
  task automatic run_burst(input string tag, input logic [AW-1:0] a,
                           input int n, input int sz, input int k, input bit exp_cross);
    logic [AW-1:0] nb, cur, total, lo, hi;
    nb    = AW'(1) << sz;
    total = AW'(n + 1) << sz;
    cur   = a & ~(nb - 1);
    lo    = a & ~(total - 1);
    hi    = lo + total;
    do_load(a, n, sz, k);
    check({tag, " R2 active"}, 64'(active), 64'(1));
    check({tag, " R9 page_cross"}, 64'(page_cross), 64'(exp_cross));
    for (int i = 0; i <= n; i++) begin
      check({tag, " R2/R3/R4/R5 beat_addr"}, 64'(beat_addr), 64'(cur));
      check({tag, " R6 word_addr"}, 64'(word_addr), 64'(cur & ~AW'(BB - 1)));
      check({tag, " R7 last"}, 64'(last), 64'(i == n));
      if (i < n) begin
        do_step();
        if (k != 0) begin
          cur = cur + nb;
          if (k == 2 && cur == hi) cur = lo;
        end
      end
    end
    do_step();
    check({tag, " R7 idle after last"}, 64'({active, last}), 64'(0));
  endtask

  task automatic t_reset();
    check("R1 active", 64'(active), 64'(0));
    check("R1 last", 64'(last), 64'(0));
    check("R1 page_cross", 64'(page_cross), 64'(0));
    check("R1 beat_addr", 64'(beat_addr), 64'(0));
  endtask

  task automatic t_incr();
    run_burst("incr_unaligned", 32'h0000_1003, 3, 2, 1, 1'b0);
    run_burst("incr_bytes", 32'h0000_0105, 4, 0, 1, 1'b0);
  endtask

  task automatic t_fixed();
    run_burst("fixed", 32'h0000_2207, 2, 1, 0, 1'b0);
  endtask

  task automatic t_wrap();
    run_burst("wrap_dw", 32'h0000_3018, 3, 3, 2, 1'b0);
    run_burst("wrap_w", 32'h0000_4034, 7, 2, 2, 1'b0);
  endtask

  task automatic t_cross();
    run_burst("R9 edge_exact", 32'h0000_0FF0, 1, 3, 1, 1'b0);
    run_burst("R9 one_past", 32'h0000_0FF8, 1, 3, 1, 1'b1);
    run_burst("R3 R9 reserved", 32'h0000_1FFC, 1, 2, 3, 1'b1);
    run_burst("R9 fixed_none", 32'h0000_0FF8, 15, 3, 0, 1'b0);
  endtask

  task automatic t_idle_hold();
    logic [AW-1:0] held;
    held = beat_addr;
    do_step();
    do_step();
    check("R8 idle addr", 64'(beat_addr), 64'(held));
    check("R8 idle active", 64'(active), 64'(0));
    do_load(32'h0000_5000, 3, 2, 1);
    repeat (3) @(negedge clk);
    check("R11 hold addr", 64'(beat_addr), 64'(32'h5000));
    check("R11 hold last", 64'(last), 64'(0));
  endtask

  task automatic t_reload();
    do_load(32'h0000_6000, 5, 2, 1);
    do_step();
    check("R10 pre", 64'(beat_addr), 64'(32'h6004));
    @(negedge clk);
    load = 1'b1; step = 1'b1; start_addr = 32'h0000_7010; beat_cnt = 8'd1; size = 3'd3; kind = 2'd1;
    @(negedge clk);
    load = 1'b0; step = 1'b0;
    check("R10 restart addr", 64'(beat_addr), 64'(32'h7010));
    check("R10 restart last", 64'(last), 64'(0));
    do_step();
    check("R10 second beat", 64'(beat_addr), 64'(32'h7018));
    check("R10 last", 64'(last), 64'(1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_incr();
    t_fixed();
    t_wrap();
    t_cross();
    t_idle_hold();
    t_reload();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule